// File: doc/BRIEF.md
# Interrupt Cause and Mask Unit

This block collects single-cycle event pulses from the rest of a network controller into a 32-bit pending-cause register. A mask register then selects which pending causes may raise the single level-sensitive interrupt line. Software sees four word registers through a small synchronous register port. One register reads the pending causes and clears them. One sets cause bits by writing ones. One sets mask bits by writing ones and reads back the mask. One clears mask bits by writing ones.

Because setting and clearing go through separate write-one registers, software never needs a read-modify-write sequence. A typical service routine reads the cause register over and over until the value it gets, ANDed with its mask, is zero. Software can also raise an interrupt itself by writing to the cause-set register.

Ten cause positions are implemented: 0 transmit descriptor written back, 1 transmit queue empty, 2 link status change, 3 receive sequence error, 4 receive minimum threshold, 6 receive overrun, 7 receive timer, 9 management access done, 10 configuration symbols seen, and 11 general-purpose input 0. All other positions are reserved and always read as zero.

Top module: `irq_cause_unit`

## Requirements
- R1: After a synchronous active-low reset, the cause register, the mask register, `irq`, `reg_rvalid` and `reg_rdata` are all zero.
- R2: An `evt_pulse` bit at an implemented position sets that cause bit at the next rising edge, and the bit then stays set until a cause read.
- R3: A write to select 1 (cause set) sets the cause bits where `reg_wdata` is one. Zero bits leave the cause register unchanged.
- R4: A write to select 2 (mask set) sets the mask bits where `reg_wdata` is one. A read of select 2 returns the current mask.
- R5: A write to select 3 (mask clear) clears the mask bits where `reg_wdata` is one. Zero bits have no effect, and all ones clears the whole mask.
- R6: A read of select 0 (cause) returns the cause value held before the read, with `reg_rvalid` high one cycle after the request. It clears all cause bits at that edge, except bits that an event in the same cycle sets.
- R7: `irq` is high exactly when the cause register ANDed with the mask register is nonzero. It follows register updates at the same edge.
- R8: The implemented-bit mask is 0x00000EDF. Reserved bits of the cause and mask registers never become one, whatever the event pulses or write data.
- R9: A write to select 0 has no effect. Reads of selects 1 and 3 return zero.
- R10: Event pulses and a cause-set write in the same cycle both take effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| evt_pulse | input | 32 | One-cycle event pulses, one per cause position |
| reg_en | input | 1 | Register access request |
| reg_wr | input | 1 | 1 = write, 0 = read |
| reg_addr | input | 2 | Register select: 0 cause, 1 cause set, 2 mask set/read, 3 mask clear |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data; zero when `reg_rvalid` is low |
| reg_rvalid | output | 1 | Read data valid, one cycle after a read request |
| irq | output | 1 | Level interrupt |

## Verification
Event pulses and register writes are due one rising edge after they are driven: the cause register, the mask register and `irq` are all registered results of that edge. Read data is due one edge after the request. The bench drives every stimulus on a falling edge and samples `irq` on the next falling edge. Each read pushes its expected word into a queue, and a monitor pops that word on the falling edge where `reg_rvalid` is high. The same-cycle read-and-event case is checked by the next cause read, which must return only the late event.

// File: rtl/irq_pkg.sv
`timescale 1ns/1ps
// Package: shared widths, register selects and cause bit positions for the
// interrupt cause/mask unit. Bit positions are fixed because event sources
// and software both decode them.
package irq_pkg;
    localparam int unsigned REG_W = 32;
    localparam int unsigned SEL_W = 2;

    typedef enum logic [SEL_W-1:0] {
        SEL_CAUSE = 2'd0,   // read returns and clears pending causes
        SEL_CSET  = 2'd1,   // write-one sets cause bits
        SEL_MASK  = 2'd2,   // write-one sets mask bits, read returns mask
        SEL_MCLR  = 2'd3    // write-one clears mask bits
    } reg_sel_e;

    localparam int unsigned EV_TX_WB   = 0;
    localparam int unsigned EV_TX_EMPT = 1;
    localparam int unsigned EV_LINK    = 2;
    localparam int unsigned EV_RX_SEQ  = 3;
    localparam int unsigned EV_RX_MIN  = 4;
    localparam int unsigned EV_RX_OVR  = 6;
    localparam int unsigned EV_RX_TMR  = 7;
    localparam int unsigned EV_MGMT    = 9;
    localparam int unsigned EV_CFG_SYM = 10;
    localparam int unsigned EV_GPI0    = 11;

    localparam logic [REG_W-1:0] IMPL_MASK =
        (REG_W'(1) << EV_TX_WB)  | (REG_W'(1) << EV_TX_EMPT) |
        (REG_W'(1) << EV_LINK)   | (REG_W'(1) << EV_RX_SEQ)  |
        (REG_W'(1) << EV_RX_MIN) | (REG_W'(1) << EV_RX_OVR)  |
        (REG_W'(1) << EV_RX_TMR) | (REG_W'(1) << EV_MGMT)    |
        (REG_W'(1) << EV_CFG_SYM)| (REG_W'(1) << EV_GPI0);
endpackage

// File: rtl/irq_cause_reg.sv
`timescale 1ns/1ps
// Pending-cause register.
// Captures event pulses and software set requests, and clears on a cause read.
// A set from an event or a write in the clearing cycle wins over the clear.
// Assumes set and clear strobes are single-cycle, already decoded by the top.
module irq_cause_reg #(
    parameter int unsigned W = 32,
    parameter logic [W-1:0] IMPL = '1
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] evt_i,
    input  logic         set_en_i,
    input  logic [W-1:0] set_bits_i,
    input  logic         rd_clr_i,
    output logic [W-1:0] cause_o
);
    logic [W-1:0] cause_q;
    logic [W-1:0] set_vec;
    logic [W-1:0] keep_vec;

    // Collect all set sources for this cycle, limited to implemented bits.
    always_comb begin
        set_vec  = (evt_i | (set_bits_i & {W{set_en_i}})) & IMPL;
        keep_vec = rd_clr_i ? '0 : cause_q;
    end

    // Cause storage: clear-on-read, then OR in new sets.
    always_ff @(posedge clk) begin
        if (!rst_n) cause_q <= '0;
        else        cause_q <= keep_vec | set_vec;
    end

    assign cause_o = cause_q;

    // R2
    evt_sets_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((evt_i & IMPL) != '0) |=> ((cause_o & $past(evt_i & IMPL)) == $past(evt_i & IMPL)));

    // R3
    sw_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        set_en_i |=> ((cause_o & $past(set_bits_i & IMPL)) == $past(set_bits_i & IMPL)));

    // R6
    rd_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_clr_i && ((evt_i & IMPL) == '0) && !set_en_i) |=> (cause_o == '0));
endmodule

// File: rtl/irq_mask_reg.sv
`timescale 1ns/1ps
// Interrupt mask register with separate write-one-to-set and
// write-one-to-clear strobes. Reserved bits are never set.
// Assumes at most one strobe per cycle; should both come, set wins.
module irq_mask_reg #(
    parameter int unsigned W = 32,
    parameter logic [W-1:0] IMPL = '1
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         set_en_i,
    input  logic         clr_en_i,
    input  logic [W-1:0] bits_i,
    output logic [W-1:0] mask_o
);
    logic [W-1:0] mask_q;
    logic [W-1:0] mask_d;

    // Next mask: drop cleared bits, then add set bits.
    always_comb begin
        mask_d = mask_q;
        if (clr_en_i) mask_d = mask_d & ~bits_i;
        if (set_en_i) mask_d = mask_d | (bits_i & IMPL);
    end

    // Mask storage.
    always_ff @(posedge clk) begin
        if (!rst_n) mask_q <= '0;
        else        mask_q <= mask_d;
    end

    assign mask_o = mask_q;

    // R4
    mask_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        set_en_i |=> ((mask_o & $past(bits_i & IMPL)) == $past(bits_i & IMPL)));

    // R5
    mask_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_en_i && !set_en_i) |=> ((mask_o & $past(bits_i)) == '0));

    // R4
    mask_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!set_en_i && !clr_en_i) |=> $stable(mask_o));
endmodule

// File: rtl/irq_read_port.sv
`timescale 1ns/1ps
// Registered read-data path. A read request selects the cause or mask value
// (zero for the write-only selects) and presents it with a valid flag one
// cycle later. Data is forced to zero while the valid flag is low.
module irq_read_port #(
    parameter int unsigned W = 32
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          rd_req_i,
    input  logic [irq_pkg::SEL_W-1:0]     sel_i,
    input  logic [W-1:0]                  cause_i,
    input  logic [W-1:0]                  mask_i,
    output logic [W-1:0]                  rdata_o,
    output logic                          rvalid_o
);
    import irq_pkg::*;

    logic [W-1:0] sel_data;

    // Pick the word that belongs to the selected register.
    always_comb begin
        case (sel_i)
            SEL_CAUSE: sel_data = cause_i;
            SEL_MASK:  sel_data = mask_i;
            default:   sel_data = '0;
        endcase
    end

    // Register the response.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rdata_o  <= '0;
            rvalid_o <= 1'b0;
        end else begin
            rvalid_o <= rd_req_i;
            rdata_o  <= rd_req_i ? sel_data : '0;
        end
    end

    // R6
    cause_rdata_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_req_i && sel_i == SEL_CAUSE) |=> (rvalid_o && rdata_o == $past(cause_i)));

    // R9
    wo_rdata_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_req_i && (sel_i == SEL_CSET || sel_i == SEL_MCLR)) |=> (rvalid_o && rdata_o == '0));
endmodule

// File: rtl/irq_cause_unit.sv
`timescale 1ns/1ps
// Interrupt cause and mask unit (top).
// Decodes the register port into strobes for the cause and mask registers,
// returns read data one cycle after a read request, and drives a level
// interrupt from the masked causes. Assumes event pulses are synchronous
// to clk and last one cycle each.
module irq_cause_unit #(
    parameter int unsigned W = irq_pkg::REG_W,
    parameter logic [W-1:0] IMPL = irq_pkg::IMPL_MASK
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic [W-1:0]               evt_pulse,
    input  logic                       reg_en,
    input  logic                       reg_wr,
    input  logic [irq_pkg::SEL_W-1:0]  reg_addr,
    input  logic [W-1:0]               reg_wdata,
    output logic [W-1:0]               reg_rdata,
    output logic                       reg_rvalid,
    output logic                       irq
);
    import irq_pkg::*;

    logic         rd_req, cause_rd, cause_set, mask_set, mask_clr;
    logic [W-1:0] cause_q, mask_q;

    // Access decode into one-cycle strobes.
    always_comb begin
        rd_req    = reg_en && !reg_wr;
        cause_rd  = rd_req && (reg_addr == SEL_CAUSE);
        cause_set = reg_en && reg_wr && (reg_addr == SEL_CSET);
        mask_set  = reg_en && reg_wr && (reg_addr == SEL_MASK);
        mask_clr  = reg_en && reg_wr && (reg_addr == SEL_MCLR);
    end

    irq_cause_reg #(.W(W), .IMPL(IMPL)) u_cause (
        .clk       (clk),
        .rst_n     (rst_n),
        .evt_i     (evt_pulse),
        .set_en_i  (cause_set),
        .set_bits_i(reg_wdata),
        .rd_clr_i  (cause_rd),
        .cause_o   (cause_q)
    );

    irq_mask_reg #(.W(W), .IMPL(IMPL)) u_mask (
        .clk     (clk),
        .rst_n   (rst_n),
        .set_en_i(mask_set),
        .clr_en_i(mask_clr),
        .bits_i  (reg_wdata),
        .mask_o  (mask_q)
    );

    irq_read_port #(.W(W)) u_rd (
        .clk     (clk),
        .rst_n   (rst_n),
        .rd_req_i(rd_req),
        .sel_i   (reg_addr),
        .cause_i (cause_q),
        .mask_i  (mask_q),
        .rdata_o (reg_rdata),
        .rvalid_o(reg_rvalid)
    );

    // Level interrupt from masked pending causes.
    assign irq = |(cause_q & mask_q);

    // R7
    irq_needs_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> (mask_q != '0 && cause_q != '0));

    // R1
    rst_quiet_chk: assert property (@(posedge clk)
        !rst_n |=> (!irq && !reg_rvalid && reg_rdata == '0));
endmodule

// File: tb/irq_cause_unit_bench.sv
`timescale 1ns/1ps
module irq_cause_unit_bench;
    import irq_pkg::*;
    localparam int unsigned W = REG_W;
    localparam logic [W-1:0] IMPL = 32'h0000_0EDF;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic [W-1:0] evt_pulse = '0;
    logic reg_en = 1'b0, reg_wr = 1'b0;
    logic [1:0] reg_addr = 2'd0;
    logic [W-1:0] reg_wdata = '0;
    logic [W-1:0] reg_rdata;
    logic reg_rvalid, irq;

    always #2.5 clk = ~clk;

    irq_cause_unit u_irq_cause_unit (
        .clk(clk), .rst_n(rst_n), .evt_pulse(evt_pulse),
        .reg_en(reg_en), .reg_wr(reg_wr), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .reg_rvalid(reg_rvalid), .irq(irq)
    );

    int checks = 0;
    int bad = 0;
    bit done = 1'b0;
    logic [W-1:0] exp_cause = '0;
    logic [W-1:0] exp_mask = '0;
    logic [W-1:0] q_val[$];
    string q_tag[$];

    task automatic check(input string tag, input logic [W-1:0] act, input logic [W-1:0] exp);
        checks++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("  test done: total=%0d bad=%0d", checks, bad);
            $finish;
        end
    endtask

    // Driver: one cycle of stimulus, starting and ending on a falling edge.
    task automatic cyc(input logic [W-1:0] ev, input logic en, input logic wr,
                       input logic [1:0] a, input logic [W-1:0] wd, input string tag);
        logic [W-1:0] nc, nm;
        evt_pulse = ev; reg_en = en; reg_wr = wr; reg_addr = a; reg_wdata = wd;
        nc = exp_cause;
        nm = exp_mask;
        if (en && !wr) begin
            q_tag.push_back(tag);
            if (a == SEL_CAUSE)     q_val.push_back(exp_cause);
            else if (a == SEL_MASK) q_val.push_back(exp_mask);
            else                    q_val.push_back('0);
            if (a == SEL_CAUSE) nc = '0;
        end
        nc = nc | (ev & IMPL);
        if (en && wr && a == SEL_CSET) nc = nc | (wd & IMPL);
        if (en && wr && a == SEL_MASK) nm = nm | (wd & IMPL);
        if (en && wr && a == SEL_MCLR) nm = nm & ~wd;
        exp_cause = nc;
        exp_mask = nm;
        @(negedge clk);
        evt_pulse = '0; reg_en = 1'b0; reg_wr = 1'b0; reg_wdata = '0;
        // R7: level follows masked causes after the edge
        check("R7 irq", {31'd0, irq}, {31'd0, |(exp_cause & exp_mask)});
    endtask

    task automatic rd(input logic [1:0] a, input string tag);
        cyc('0, 1'b1, 1'b0, a, '0, tag);
    endtask
    task automatic wr(input logic [1:0] a, input logic [W-1:0] d, input string tag);
        cyc('0, 1'b1, 1'b1, a, d, tag);
    endtask
    task automatic ev(input logic [W-1:0] e, input string tag);
        cyc(e, 1'b0, 1'b0, 2'd0, '0, tag);
    endtask

    // Monitor: scoreboard pop on every valid read response.
    always @(negedge clk) begin
        if (rst_n && reg_rvalid) begin
            if (q_val.size() == 0) begin
                check("R6 unexpected rvalid", 32'd1, 32'd0);
            end else begin
                check(q_tag.pop_front(), reg_rdata, q_val.pop_front());
            end
        end
    end

    // Watchdog.
    initial begin
        repeat (100000) @(posedge clk);
        checks++;
        bad++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1: outputs quiet in reset
        check("R1 irq", {31'd0, irq}, 32'd0);
        check("R1 rvalid", {31'd0, reg_rvalid}, 32'd0);
        check("R1 rdata", reg_rdata, 32'd0);
        rst_n = 1'b1;
        @(negedge clk);
        rd(SEL_CAUSE, "R1 cause");
        rd(SEL_MASK, "R1 mask");

        // R2: event captured and held, masked off
        ev(32'h4, "R2");
        ev('0, "R2");
        ev('0, "R2");
        rd(SEL_CAUSE, "R2 held cause");
        rd(SEL_CAUSE, "R6 cleared");

        // R4: mask set and read back, irq rises
        wr(SEL_MASK, 32'h4, "R4");
        rd(SEL_MASK, "R4 mask read");
        ev(32'h4, "R7");

        // R6: event during a cause read survives
        cyc(32'h80, 1'b1, 1'b0, SEL_CAUSE, '0, "R6 read with event");
        rd(SEL_CAUSE, "R6 late event kept");

        // R3: software set, zero write no effect
        wr(SEL_CSET, 32'h800, "R3");
        wr(SEL_CSET, 32'h0, "R3");
        rd(SEL_CAUSE, "R3 set bits");

        // R8: reserved bits never set
        wr(SEL_CSET, 32'hFFFF_FFFF, "R8");
        rd(SEL_CAUSE, "R8 cause reserved");
        ev(32'h0000_F020, "R8");
        rd(SEL_CAUSE, "R8 reserved events");
        wr(SEL_MASK, 32'hFFFF_FFFF, "R8");
        rd(SEL_MASK, "R8 mask reserved");

        // R5: mask clear
        wr(SEL_MCLR, 32'h0, "R5");
        rd(SEL_MASK, "R5 zero clear");
        wr(SEL_MCLR, 32'h4, "R5");
        rd(SEL_MASK, "R5 bit2 cleared");
        ev(32'h4, "R7 masked bit");
        wr(SEL_MCLR, 32'hFFFF_FFFF, "R5");
        rd(SEL_MASK, "R5 all cleared");

        // R9: write to cause select ignored, write-only reads zero
        wr(SEL_CSET, 32'h1, "R9");
        wr(SEL_CAUSE, 32'hFFFF_FFFF, "R9");
        rd(SEL_CSET, "R9 cset read");
        rd(SEL_MCLR, "R9 mclr read");
        rd(SEL_CAUSE, "R9 cause unchanged");

        // R10: event and software set together
        cyc(32'h10, 1'b1, 1'b1, SEL_CSET, 32'h200, "R10");
        rd(SEL_CAUSE, "R10 combined");

        // R7: service loop until masked causes are zero
        wr(SEL_MASK, 32'hC0, "R7");
        ev(32'hC0, "R7");
        for (int n = 0; n < 4 && (exp_cause & exp_mask) != '0; n++)
            rd(SEL_CAUSE, "R7 service read");
        ev('0, "R7");
        ev('0, "R7");
        check("R6 scoreboard drained", q_val.size(), 32'd0);
        finish_run();
    end
endmodule